// File: doc/BRIEF.md
# SIMT Divergence Mask Controller

This block steers one group of lanes that share a single instruction stream. Every lane runs the same instruction on its own registers and data. The block decides which lanes are switched on for each instruction, and it decides which instruction is fetched next. Instructions arrive one at a time on a valid/ready stream. Each one carries an opcode and its operands.

A sequential op steps the program counter by one, and a jump loads a target. A conditional branch reads an 8-bit per-lane condition vector, which comes from the lanes on a second valid/ready stream. If the active lanes disagree on the condition, the group is split. The then-path runs first with the else-lanes switched off. When that path reaches the reconvergence PC, execution moves to the else-path with the then-lanes switched off. When the else-path reaches the same PC, the mask that was live before the branch comes back. If the active lanes all agree, only the chosen path runs and no state is saved.

Nested splits are tracked on a four-entry reconvergence stack. Each entry holds:
- the else-path PC;
- the else-path mask;
- the reconvergence PC;
- the enclosing mask;
- a flag that records which path is running.

There are no bypasses, so a branch waits until the instruction that produces its condition has finished and the condition vector is valid.

Back-pressure rules:
- An instruction transfers on a cycle with both `in_valid` and `in_ready` high.
- While `in_valid` is high, the opcode and operands must stay stable until the transfer.
- A non-branch op is always ready.
- A branch is ready only while `cond_valid` is high, and the condition vector transfers on that same cycle.
- `cond_ready` is high whenever a branch is on offer.

Top module: `simt_pred_unit`

## Requirements
- R1: After reset, `cur_pc` is 0, `cur_mask` is all ones (8'hFF) and `ovf_err` is 0.
- R2: An accepted sequential op (`in_op` 2'b00, and 2'b11, which is reserved and treated the same) sets `cur_pc` to `cur_pc`+1 and leaves `cur_mask` unchanged. A cycle with no transfer changes neither output.
- R3: An accepted jump (`in_op` 2'b01) sets `cur_pc` to `in_target` and leaves the mask unchanged.
- R4: A branch (`in_op` 2'b10) is uniform when the active lanes all agree. If every active lane has a condition bit of 1, the result is `cur_pc`+1. If every active lane has a bit of 0, the result is `in_else_pc`. In both cases the mask is unchanged and nothing is pushed. Condition bits of inactive lanes are ignored.
- R5: A divergent branch pushes an entry. It sets `cur_mask` to `active & cond`, where bit i is lane i, and sets `cur_pc` to `cur_pc`+1. The mask never becomes zero.
- R6: The then-path ends when a resolved next PC equals the top entry's reconvergence PC. At that point `cur_pc` becomes the entry's else PC and `cur_mask` becomes `active & ~cond` of the split.
- R7: The else-path ends when a resolved next PC equals the reconvergence PC. The entry is then popped, `cur_pc` becomes the reconvergence PC and `cur_mask` becomes the mask from before the split.
- R8: Up to four splits nest, and they unwind in last-in, first-out order.
- R9: A divergent branch on a full stack sets `ovf_err`. The stack and the mask stay unchanged, and `cur_pc` steps by one. `ovf_err` holds until reset.
- R10: A branch with `cond_valid` low is not accepted: `in_ready` is low and the state holds. `cond_ready` is high while a branch is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| in_op | input | 2 | 00 sequential, 01 jump, 10 branch, 11 reserved (sequential) |
| in_target | input | 16 | Jump target PC |
| in_else_pc | input | 16 | Branch else-path start PC |
| in_reconv_pc | input | 16 | Branch reconvergence PC |
| cond_valid | input | 1 | Condition vector valid |
| cond_ready | output | 1 | Condition vector being consumed by an offered branch |
| cond | input | 8 | Per-lane condition, 1 selects the then-path |
| cur_pc | output | 16 | Next PC to fetch |
| cur_mask | output | 8 | Active lane mask |
| ovf_err | output | 1 | Sticky stack overflow flag |

## Verification
Branch resolution and reconvergence can fall in the same cycle. This happens when a uniform branch inside a then-path resolves straight to the top entry's reconvergence PC. The bench provokes this with a branch whose active lanes all vote for the else-path and whose else PC equals the open reconvergence PC. It expects the stack to switch to the enclosing else-path at once, rather than landing on the reconvergence PC. A second overlap provoked is a divergent branch meeting a full stack, which is judged by the flag, the unchanged mask and the single-step PC.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    OP_SEQ    = 2'b00,
    OP_JUMP   = 2'b01,
    OP_BRANCH = 2'b10,
    OP_RSVD   = 2'b11
  } op_e;
endpackage

// File: rtl/simt_cond_split.sv
module simt_cond_split #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] then_mask,
  output logic [LANES-1:0] else_mask,
  output logic             all_else,
  output logic             diverge
);
  always_comb begin
    then_mask = active & cond;
    else_mask = active & ~cond;
    all_else  = (then_mask == '0);
    diverge   = (then_mask != '0) && (else_mask != '0);
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int DEPTH = 4,
  parameter int PCW   = 16,
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flip,
  input  logic [PCW-1:0]   w_else_pc,
  input  logic [LANES-1:0] w_else_mask,
  input  logic [PCW-1:0]   w_reconv,
  input  logic [LANES-1:0] w_outer,
  output logic [PCW-1:0]   t_else_pc,
  output logic [LANES-1:0] t_else_mask,
  output logic [PCW-1:0]   t_reconv,
  output logic [LANES-1:0] t_outer,
  output logic             t_in_else,
  output logic             empty,
  output logic             full
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PCW-1:0]   else_pc_q   [DEPTH];
  logic [LANES-1:0] else_mask_q [DEPTH];
  logic [PCW-1:0]   reconv_q    [DEPTH];
  logic [LANES-1:0] outer_q     [DEPTH];
  logic [DEPTH-1:0] in_else_q;
  logic [SPW-1:0]   sp_q;
  logic [IXW-1:0]   top_ix;
  logic [IXW-1:0]   wr_ix;

  assign empty  = (sp_q == '0);
  assign full   = (sp_q == SPW'(DEPTH));
  assign top_ix = empty ? '0 : IXW'(sp_q - SPW'(1));
  assign wr_ix  = full ? '0 : IXW'(sp_q);

  assign t_else_pc   = else_pc_q[top_ix];
  assign t_else_mask = else_mask_q[top_ix];
  assign t_reconv    = reconv_q[top_ix];
  assign t_outer     = outer_q[top_ix];
  assign t_in_else   = in_else_q[top_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q      <= '0;
      in_else_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        else_pc_q[i]   <= '0;
        else_mask_q[i] <= '0;
        reconv_q[i]    <= '0;
        outer_q[i]     <= '0;
      end
    end else if (push && !full) begin
      else_pc_q[wr_ix]   <= w_else_pc;
      else_mask_q[wr_ix] <= w_else_mask;
      reconv_q[wr_ix]    <= w_reconv;
      outer_q[wr_ix]     <= w_outer;
      in_else_q[wr_ix]   <= 1'b0;
      sp_q               <= sp_q + SPW'(1);
    end else if (pop && !empty) begin
      sp_q <= sp_q - SPW'(1);
    end else if (flip && !empty) begin
      in_else_q[top_ix] <= 1'b1;
    end
  end
endmodule

// File: rtl/simt_pred_unit.sv
module simt_pred_unit
  import simt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PCW   = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [PCW-1:0]   in_target,
  input  logic [PCW-1:0]   in_else_pc,
  input  logic [PCW-1:0]   in_reconv_pc,
  input  logic             cond_valid,
  output logic             cond_ready,
  input  logic [LANES-1:0] cond,
  output logic [PCW-1:0]   cur_pc,
  output logic [LANES-1:0] cur_mask,
  output logic             ovf_err
);
  logic [PCW-1:0]   pc_q, pc_d, cand_pc, pc_inc;
  logic [LANES-1:0] mask_q, mask_d;
  logic             err_q, err_d;
  logic             is_branch, fire;
  logic [LANES-1:0] then_m, else_m;
  logic             all_else, diverge;
  logic             push, pop, flip;
  logic [PCW-1:0]   top_else_pc, top_reconv;
  logic [LANES-1:0] top_else_mask, top_outer;
  logic             top_in_else, stk_empty, stk_full;

  assign is_branch  = (op_e'(in_op) == OP_BRANCH);
  assign in_ready   = !is_branch || cond_valid;
  assign cond_ready = in_valid && is_branch;
  assign fire       = in_valid && in_ready;
  assign pc_inc     = pc_q + PCW'(1);

  simt_cond_split #(.LANES(LANES)) u_split (
    .active    (mask_q),
    .cond      (cond),
    .then_mask (then_m),
    .else_mask (else_m),
    .all_else  (all_else),
    .diverge   (diverge)
  );

  simt_reconv_stack #(.DEPTH(DEPTH), .PCW(PCW), .LANES(LANES)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pop         (pop),
    .flip        (flip),
    .w_else_pc   (in_else_pc),
    .w_else_mask (else_m),
    .w_reconv    (in_reconv_pc),
    .w_outer     (mask_q),
    .t_else_pc   (top_else_pc),
    .t_else_mask (top_else_mask),
    .t_reconv    (top_reconv),
    .t_outer     (top_outer),
    .t_in_else   (top_in_else),
    .empty       (stk_empty),
    .full        (stk_full)
  );

  // Resolve the next PC the instruction itself asks for.
  always_comb begin
    cand_pc = pc_inc;
    case (op_e'(in_op))
      OP_JUMP:   cand_pc = in_target;
      OP_BRANCH: cand_pc = all_else ? in_else_pc : pc_inc;
      default:   cand_pc = pc_inc;
    endcase
  end

  // Split, reconvergence and plain stepping; a split has priority.
  always_comb begin
    pc_d   = pc_q;
    mask_d = mask_q;
    err_d  = err_q;
    push   = 1'b0;
    pop    = 1'b0;
    flip   = 1'b0;
    if (fire) begin
      if (is_branch && diverge) begin
        pc_d = pc_inc;
        if (stk_full) begin
          err_d = 1'b1;
        end else begin
          push   = 1'b1;
          mask_d = then_m;
        end
      end else if (!stk_empty && (cand_pc == top_reconv)) begin
        if (!top_in_else) begin
          flip   = 1'b1;
          pc_d   = top_else_pc;
          mask_d = top_else_mask;
        end else begin
          pop    = 1'b1;
          pc_d   = top_reconv;
          mask_d = top_outer;
        end
      end else begin
        pc_d = cand_pc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mask_q <= '1;
      err_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mask_q <= mask_d;
      err_q  <= err_d;
    end
  end

  assign cur_pc   = pc_q;
  assign cur_mask = mask_q;
  assign ovf_err  = err_q;
endmodule

// File: rtl/simt_pred_checker.sv
module simt_pred_checker
  import simt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PCW   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_op,
  input logic [PCW-1:0]   in_target,
  input logic             cond_valid,
  input logic             cond_ready,
  input logic [PCW-1:0]   cur_pc,
  input logic [LANES-1:0] cur_mask,
  input logic             ovf_err,
  input logic             stk_empty
);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(cur_pc) && $stable(cur_mask)));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b00 && stk_empty)
      |=> (cur_pc == $past(cur_pc) + PCW'(1)) && $stable(cur_mask));

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b01 && stk_empty)
      |=> cur_pc == $past(in_target));

  assert_mask_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mask != '0);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_wait_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && !cond_valid) |-> (!in_ready && cond_ready));
endmodule

bind simt_pred_unit simt_pred_checker #(.LANES(LANES), .PCW(PCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_target  (in_target),
  .cond_valid (cond_valid),
  .cond_ready (cond_ready),
  .cur_pc     (cur_pc),
  .cur_mask   (cur_mask),
  .ovf_err    (ovf_err),
  .stk_empty  (stk_empty)
);

// File: tb/sim_simt_pred_unit.sv
`timescale 1ns/1ps
module sim_simt_pred_unit;
  localparam int LANES = 8;
  localparam int PCW   = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_op = 2'b00;
  logic [PCW-1:0]   in_target = '0;
  logic [PCW-1:0]   in_else_pc = '0;
  logic [PCW-1:0]   in_reconv_pc = '0;
  logic             cond_valid = 1'b0;
  logic             cond_ready;
  logic [LANES-1:0] cond = '0;
  logic [PCW-1:0]   cur_pc;
  logic [LANES-1:0] cur_mask;
  logic             ovf_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  simt_pred_unit #(.LANES(LANES), .PCW(PCW), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_target(in_target), .in_else_pc(in_else_pc),
    .in_reconv_pc(in_reconv_pc), .cond_valid(cond_valid), .cond_ready(cond_ready),
    .cond(cond), .cur_pc(cur_pc), .cur_mask(cur_mask), .ovf_err(ovf_err)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic expect_state(input string req, input int pc, input int mask);
    chk(req, "pc", int'(cur_pc), pc);
    chk(req, "mask", int'(cur_mask), mask);
  endtask

  // Offer one instruction at the falling edge, let it transfer, sample 1 ns after the edge.
  task automatic issue(input logic [1:0] op, input int tgt, input int els,
                       input int rcv, input int c);
    @(negedge clk);
    in_valid     = 1'b1;
    in_op        = op;
    in_target    = PCW'(tgt);
    in_else_pc   = PCW'(els);
    in_reconv_pc = PCW'(rcv);
    cond         = LANES'(c);
    cond_valid   = (op == 2'b10);
    @(posedge clk);
    #1;
    in_valid   = 1'b0;
    cond_valid = 1'b0;
  endtask

  task automatic seq_op();  issue(2'b00, 0, 0, 0, 0); endtask
  task automatic jump(input int t); issue(2'b01, t, 0, 0, 0); endtask
  task automatic branch(input int c, input int els, input int rcv); issue(2'b10, 0, els, rcv, c); endtask

  task automatic t_reset();
    expect_state("R1", 0, 8'hFF);
    chk("R1", "ovf_err", int'(ovf_err), 0);
  endtask

  task automatic t_seq();
    seq_op(); seq_op(); seq_op();
    expect_state("R2", 3, 8'hFF);
    issue(2'b11, 0, 0, 0, 0);
    expect_state("R2", 4, 8'hFF);
    @(posedge clk); #1;
    expect_state("R2", 4, 8'hFF);
  endtask

  task automatic t_jump();
    jump(100);
    expect_state("R3", 100, 8'hFF);
  endtask

  task automatic t_uniform();
    branch(8'hFF, 200, 300);
    expect_state("R4", 101, 8'hFF);
    branch(8'h00, 200, 300);
    expect_state("R4", 200, 8'hFF);
  endtask

  task automatic t_diverge();
    branch(8'h0F, 210, 220);
    expect_state("R5", 201, 8'h0F);
    seq_op();
    jump(220);
    expect_state("R6", 210, 8'hF0);
    for (int i = 0; i < 10; i++) seq_op();
    expect_state("R7", 220, 8'hFF);
  endtask

  task automatic t_nest();
    branch(8'h3C, 240, 260);
    expect_state("R8", 221, 8'h3C);
    branch(8'h0F, 230, 235);
    expect_state("R8", 222, 8'h0C);
    // Inactive lanes vote differently; only lanes 2,3 count (R4).
    branch(8'hCC, 500, 600);
    expect_state("R4", 223, 8'h0C);
    jump(235);
    expect_state("R8", 230, 8'h30);
    jump(235);
    expect_state("R8", 235, 8'h3C);
    jump(260);
    expect_state("R8", 240, 8'hC3);
    jump(260);
    expect_state("R8", 260, 8'hFF);
  endtask

  task automatic t_cond_wait();
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b10; cond = 8'h01; cond_valid = 1'b0;
    in_else_pc = PCW'(270); in_reconv_pc = PCW'(280);
    #1;
    chk("R10", "in_ready", int'(in_ready), 0);
    chk("R10", "cond_ready", int'(cond_ready), 1);
    @(posedge clk); #1;
    expect_state("R10", 260, 8'hFF);
    @(negedge clk);
    cond_valid = 1'b1;
    #1;
    chk("R10", "in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1'b0; cond_valid = 1'b0;
    expect_state("R10", 261, 8'h01);
  endtask

  task automatic t_same_cycle();
    // Uniform else-vote whose target is the open reconvergence PC.
    branch(8'h00, 280, 999);
    expect_state("R6", 270, 8'hFE);
    jump(280);
    expect_state("R7", 280, 8'hFF);
  endtask

  task automatic t_overflow();
    branch(8'h7F, 900, 901);
    branch(8'h3F, 900, 902);
    branch(8'h1F, 900, 903);
    branch(8'h0F, 900, 904);
    expect_state("R8", 284, 8'h0F);
    chk("R9", "ovf_err before", int'(ovf_err), 0);
    branch(8'h07, 900, 905);
    expect_state("R9", 285, 8'h0F);
    chk("R9", "ovf_err", int'(ovf_err), 1);
    seq_op();
    chk("R9", "ovf_err sticky", int'(ovf_err), 1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected done", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_seq();
    t_jump();
    t_uniform();
    t_diverge();
    t_nest();
    t_cond_wait();
    t_same_cycle();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule